// File: doc/BRIEF.md
# Debug memory access port engine

This block lets a debugger reach system memory through a handful of registers. The debugger issues register accesses on a small request port. A control/status word holds the transfer size, the protection and cache attributes and the address-step mode. A transfer address register holds the target address. A data register and four banked data windows turn each debugger access into exactly one memory transaction on a request/acknowledge bus master port. The response then returns to the debugger.

The debugger request port is a valid/ready stream. A request (`dbg_valid`) is taken in the cycle where `dbg_ready` is also high, and the host must hold its fields stable until then. `dbg_ready` stays low while a memory transaction is outstanding, so a data-register access stalls the debugger until the bus acknowledges. Every accepted request produces one `rsp_valid` pulse. The response has no back-pressure. On the bus side, `bus_req` is held with all fields stable until the cycle where `bus_ack` is high. `bus_rdata` and `bus_err` are sampled in that cycle.

Two status inputs gate the traffic. A debug-enable input blocks all transfers. A secure-enable input blocks transfers marked secure. A blocked access issues nothing on the bus and is answered with an error.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset the control/status word reads 0x00303002 plus its status bits: size 2, step mode 0, protection 3'b011, cache 0, shareability 2'b11. The transfer address reads 0.
- R2: The control/status word (offset 0x00) has this layout: size [2:0], step mode [4:3], bus busy [8], debug-enable status [9], secure-enable status [10], protection [14:12], cache [19:16], shareability [21:20]. Bits 8 to 10 are read-only and all other bits read 0. The transfer address (0x04) reads back what was written. Any other offset that is not a data register reads 0, ignores writes and returns no error.
- R3: An access to the data register (0x0C) issues one bus transaction. It uses the transfer address, the protection field and the size code from the control/status word: 0 byte, 1 halfword, 2 word, and 3 to 7 treated as word. It also carries the access direction and the write data. All bus fields stay stable while `bus_req` waits for `bus_ack`.
- R4: Register accesses and blocked accesses respond one cycle after acceptance. Data accesses respond one cycle after `bus_ack`, with `rsp_err` equal to `bus_err`. A read returns `bus_rdata`.
- R5: With step mode 2'b01, a data-register transfer that completes without error adds 1 << size to the transfer address. The carry is confined to address bits [9:0], so the address wraps inside its 1 KB window and bits above 9 are kept.
- R6: The transfer address does not step after an error response, and it does not step in any step mode other than 2'b01.
- R7: Banked offsets 0x10, 0x14, 0x18 and 0x1C are selected by debug address bits [3:2] when bits [7:4] equal 1. They access transfer address + 0, 4, 8 or 12 as a word (size code 2) whatever the size field holds, and they never step the address.
- R8: While `dbg_en_i` is low at acceptance, a data access issues no bus transaction, responds with `rsp_err` high and leaves the address unchanged.
- R9: A transfer is secure when protection bit 1 is 0. While `sec_en_i` is low, secure transfers are blocked as in R8 and non-secure transfers proceed.
- R10: `xfer_active` and `bus_req` are high from the cycle after a data access is accepted up to and including the cycle where `bus_ack` is high. `dbg_ready` is low during those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dbg_en_i | input | 1 | Debug enable; low blocks every bus transfer |
| sec_en_i | input | 1 | Secure enable; low blocks secure transfers |
| dbg_valid | input | 1 | Debugger request valid |
| dbg_ready | output | 1 | Request accepted when high with dbg_valid |
| dbg_addr | input | REG_AW | Register byte offset |
| dbg_write | input | 1 | 1 = register write, 0 = read |
| dbg_wdata | input | DATA_W | Register write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| rsp_err | output | 1 | Error flag, valid with rsp_valid |
| bus_req | output | 1 | Bus transaction request |
| bus_ack | input | 1 | Bus transaction completion |
| bus_addr | output | ADDR_W | Transaction byte address |
| bus_size | output | 3 | Size code 0/1/2 = 1/2/4 bytes |
| bus_prot | output | 3 | Protection attributes |
| bus_write | output | 1 | 1 = write transaction |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled with bus_ack |
| bus_err | input | 1 | Error response, sampled with bus_ack |
| xfer_active | output | 1 | A bus transaction is outstanding |

## Verification
The hardest condition to reach is the address step at the edge of a 1 KB window, combined with each size and with an errored completion. The sum must carry out of bit 9 without touching the upper bits, and it must not be taken at all on an error. The bench loads the transfer address just below the window edge, at 0x3FE and 0x3FC with nonzero upper bits, and steps across the edge with byte, halfword, word and an out-of-range size code. Its bus responder injects an error response and varies the acknowledge latency, and the bench reads the address back after every transfer.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  typedef enum logic [2:0] {K_NONE, K_CSW, K_TAR, K_DRW, K_BANK} kind_e;

  typedef struct packed {
    logic [2:0] prot;
    logic [3:0] cache;
    logic [1:0] domain;
    logic [1:0] incmode;
    logic [2:0] size;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{prot: 3'b011, cache: 4'h0, domain: 2'b11,
                                 incmode: 2'b00, size: 3'b010};
  localparam logic [1:0] INC_SINGLE = 2'b01;

  // size codes above word are treated as word
  function automatic logic [1:0] eff_size(input logic [2:0] s);
    return (s > 3'd2) ? 2'd2 : s[1:0];
  endfunction

  function automatic kind_e decode(input logic [7:0] a);
    kind_e k;
    if (a == 8'h00)                            k = K_CSW;
    else if (a == 8'h04)                       k = K_TAR;
    else if (a == 8'h0C)                       k = K_DRW;
    else if (a[7:4] == 4'h1 && a[1:0] == 2'b0) k = K_BANK;
    else                                       k = K_NONE;
    return k;
  endfunction

  function automatic logic [31:0] csw_word(input ctl_t c, input logic busy,
                                           input logic den, input logic sen);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = c.size;
    w[4:3]   = c.incmode;
    w[8]     = busy;
    w[9]     = den;
    w[10]    = sen;
    w[14:12] = c.prot;
    w[19:16] = c.cache;
    w[21:20] = c.domain;
    return w;
  endfunction

  function automatic ctl_t csw_unpack(input logic [31:0] w);
    ctl_t c;
    c.size    = w[2:0];
    c.incmode = w[4:3];
    c.prot    = w[14:12];
    c.cache   = w[19:16];
    c.domain  = w[21:20];
    return c;
  endfunction

endpackage

// File: rtl/dmp_regs.sv
module dmp_regs
  import dmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csw_we,
  input  logic              tar_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] tar_stepped,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] tar
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= CTL_RESET;
      tar <= '0;
    end else begin
      if (csw_we) ctl <= csw_unpack(32'(wdata));
      if (tar_we)       tar <= ADDR_W'(wdata);
      else if (step_en) tar <= tar_stepped;
    end
  end

endmodule

// File: rtl/dmp_addr_gen.sv
module dmp_addr_gen
  import dmp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WRAP_BITS = 10
) (
  input  logic [ADDR_W-1:0] tar,
  input  ctl_t              ctl,
  input  logic              is_bank,
  input  logic [1:0]        bank_idx,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [2:0]        xfer_size,
  output logic [ADDR_W-1:0] tar_stepped
);

  logic [1:0]           esz;
  logic [WRAP_BITS-1:0] low_sum;

  always_comb begin
    esz         = eff_size(ctl.size);
    // carry stays inside the wrap window
    low_sum     = tar[WRAP_BITS-1:0] + (WRAP_BITS'(1) << esz);
    tar_stepped = {tar[ADDR_W-1:WRAP_BITS], low_sum};
    xfer_addr   = is_bank ? (tar + ADDR_W'({bank_idx, 2'b00})) : tar;
    xfer_size   = is_bank ? 3'd2 : {1'b0, esz};
  end

endmodule

// File: rtl/dmp_bus_fsm.sv
module dmp_bus_fsm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [2:0]        st_size,
  input  logic [2:0]        st_prot,
  input  logic              st_write,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              st_step,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [2:0]        bus_prot,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done,
  output logic              step_en
);

  logic busy, step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step_q    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_prot  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      step_q    <= st_step;
      bus_addr  <= st_addr;
      bus_size  <= st_size;
      bus_prot  <= st_prot;
      bus_write <= st_write;
      bus_wdata <= st_wdata;
    end else if (busy && bus_ack) begin
      busy <= 1'b0;
    end
  end

  assign bus_req = busy;
  assign done    = busy && bus_ack;
  assign step_en = done && !bus_err && step_q;

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 8,
  parameter int WRAP_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en_i,
  input  logic              sec_en_i,
  input  logic              dbg_valid,
  output logic              dbg_ready,
  input  logic [REG_AW-1:0] dbg_addr,
  input  logic              dbg_write,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [2:0]        bus_prot,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              xfer_active
);

  ctl_t              ctl;
  logic [ADDR_W-1:0] tar, xfer_addr, tar_stepped;
  logic [2:0]        xfer_size;
  logic              hi_zero, accept, is_data, allowed, start;
  logic              csw_we, tar_we, done, step_en, step_flag;
  kind_e             kind;
  logic [DATA_W-1:0] reg_rdata;

  generate
    if (REG_AW > 8) begin : g_hi
      assign hi_zero = ~|dbg_addr[REG_AW-1:8];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign kind      = hi_zero ? decode(dbg_addr[7:0]) : K_NONE;
  assign dbg_ready = !bus_req;
  assign accept    = dbg_valid && dbg_ready;
  assign is_data   = (kind == K_DRW) || (kind == K_BANK);
  // secure when protection bit 1 is clear
  assign allowed   = dbg_en_i && (sec_en_i || ctl.prot[1]);
  assign start     = accept && is_data && allowed;
  assign csw_we    = accept && dbg_write && (kind == K_CSW);
  assign tar_we    = accept && dbg_write && (kind == K_TAR);
  assign step_flag = (kind == K_DRW) && (ctl.incmode == INC_SINGLE);
  assign xfer_active = bus_req;

  always_comb begin
    case (kind)
      K_CSW:   reg_rdata = DATA_W'(csw_word(ctl, bus_req, dbg_en_i, sec_en_i));
      K_TAR:   reg_rdata = DATA_W'(tar);
      default: reg_rdata = '0;
    endcase
  end

  dmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .csw_we(csw_we), .tar_we(tar_we),
    .wdata(dbg_wdata), .step_en(step_en), .tar_stepped(tar_stepped),
    .ctl(ctl), .tar(tar)
  );

  dmp_addr_gen #(.ADDR_W(ADDR_W), .WRAP_BITS(WRAP_BITS)) u_agen (
    .tar(tar), .ctl(ctl), .is_bank(kind == K_BANK), .bank_idx(dbg_addr[3:2]),
    .xfer_addr(xfer_addr), .xfer_size(xfer_size), .tar_stepped(tar_stepped)
  );

  dmp_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .st_addr(xfer_addr), .st_size(xfer_size), .st_prot(ctl.prot),
    .st_write(dbg_write), .st_wdata(dbg_wdata), .st_step(step_flag),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_prot(bus_prot),
    .bus_write(bus_write), .bus_wdata(bus_wdata),
    .done(done), .step_en(step_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !start) begin
        rsp_valid <= 1'b1;
        rsp_err   <= is_data;
        rsp_rdata <= dbg_write ? '0 : reg_rdata;
      end else if (done) begin
        rsp_valid <= 1'b1;
        rsp_err   <= bus_err;
        rsp_rdata <= bus_write ? '0 : bus_rdata;
      end
    end
  end

endmodule

// File: rtl/dbg_mem_port_chk.sv
module dbg_mem_port_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_en_i,
  input logic              sec_en_i,
  input logic              dbg_valid,
  input logic              dbg_ready,
  input logic              rsp_valid,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [2:0]        bus_prot,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              xfer_active
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size)
      && $stable(bus_prot) && $stable(bus_write) && $stable(bus_wdata));

  assert_rsp_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dbg_valid && dbg_ready) || $past(bus_req && bus_ack));

  assert_word_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size <= 3'd2);

  assert_dbg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dbg_en_i));

  assert_sec_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(sec_en_i) || bus_prot[1]));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !dbg_ready && xfer_active);

endmodule

bind dbg_mem_port dbg_mem_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en_i(dbg_en_i), .sec_en_i(sec_en_i),
  .dbg_valid(dbg_valid), .dbg_ready(dbg_ready), .rsp_valid(rsp_valid),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_prot(bus_prot), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .xfer_active(xfer_active)
);

// File: tb/test_dbg_mem_port.sv
module test_dbg_mem_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en_i = 1'b1, sec_en_i = 1'b1;
  logic        dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [7:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic        dbg_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_req, bus_ack = 1'b0, bus_write, bus_err = 1'b0, xfer_active;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [2:0]  bus_size, bus_prot;

  dbg_mem_port i_dbg_mem_port (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int bus_cnt = 0, act_cnt = 0, wait_cnt = 0, resp_lat = 0;
  bit resp_err = 0, mon_on = 0;
  logic [31:0] exp_addr = '0;
  logic [31:0] seen_addr, seen_wdata;
  logic [2:0]  seen_size, seen_prot;
  logic        seen_write;

  // reference model state
  logic [31:0] m_tar = '0;
  logic [2:0]  m_size = 3'd2, m_prot = 3'b011;
  logic [1:0]  m_inc = 2'd0, m_dom = 2'b11;
  logic [3:0]  m_cache = 4'h0;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'hC3A5_0F00;
  endfunction

  function automatic logic [31:0] csw_exp();
    return 32'(m_size) | (32'(m_inc) << 3) | (32'(dbg_en_i) << 9) |
           (32'(sec_en_i) << 10) | (32'(m_prot) << 12) |
           (32'(m_cache) << 16) | (32'(m_dom) << 20);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus responder
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
      end else if (bus_req) begin
        if (wait_cnt >= resp_lat) begin
          bus_ack    = 1'b1;
          bus_err    = resp_err;
          bus_rdata  = mem_val(bus_addr);
          seen_addr  = bus_addr;
          seen_size  = bus_size;
          seen_prot  = bus_prot;
          seen_write = bus_write;
          seen_wdata = bus_wdata;
          bus_cnt++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R10", "xfer_active vs bus_req", 32'(xfer_active), 32'(bus_req));
      if (bus_req) begin
        chk("R3", "bus_addr each cycle", bus_addr, exp_addr);
        chk("R10", "dbg_ready while busy", 32'(dbg_ready), 32'd0);
      end
      if (xfer_active) act_cnt++;
    end
  end

  task automatic xact(input logic [7:0] a, input bit w, input logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    dbg_valid = 1'b1; dbg_addr = a; dbg_write = w; dbg_wdata = d;
    while (!dbg_ready) @(negedge clk);
    @(negedge clk);
    dbg_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic reg_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic er;
    xact(a, 1'b0, '0, rd, er);
    chk(req, "register read", rd, exp);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    xact(a, 1'b1, d, rd, er);
  endtask

  task automatic set_csw(input logic [2:0] sz, input logic [1:0] inc,
                         input logic [2:0] pr, input logic [3:0] ca, input logic [1:0] dm);
    m_size = sz; m_inc = inc; m_prot = pr; m_cache = ca; m_dom = dm;
    // read-only and unused bits set to show they are ignored
    reg_wr(8'h00, 32'h8000_0700 | 32'(sz) | (32'(inc) << 3) | (32'(pr) << 12) |
                  (32'(ca) << 16) | (32'(dm) << 20));
  endtask

  task automatic set_tar(input logic [31:0] t);
    m_tar = t;
    reg_wr(8'h04, t);
  endtask

  task automatic data_acc(input logic [7:0] a, input bit w, input logic [31:0] d,
                          input bit rerr, input int lat, input string req);
    logic [31:0] rd; logic er;
    bit bank, blocked;
    int n0, a0;
    logic [1:0] es;
    bank    = (a[7:4] == 4'h1);
    blocked = !dbg_en_i || (!sec_en_i && !m_prot[1]);
    es      = bank ? 2'd2 : ((m_size > 3'd2) ? 2'd2 : m_size[1:0]);
    exp_addr = bank ? (m_tar + 32'(a[3:2]) * 4) : m_tar;
    resp_err = rerr; resp_lat = lat;
    n0 = bus_cnt; a0 = act_cnt;
    xact(a, w, d, rd, er);
    if (blocked) begin
      chk(req, "blocked error", 32'(er), 32'd1);
      chk(req, "blocked bus count", 32'(bus_cnt), 32'(n0));
    end else begin
      chk(req, "bus count", 32'(bus_cnt), 32'(n0 + 1));
      chk(req, "bus_addr", seen_addr, exp_addr);
      chk(req, "bus_size", 32'(seen_size), 32'(es));
      chk(req, "bus_prot", 32'(seen_prot), 32'(m_prot));
      chk(req, "bus_write", 32'(seen_write), 32'(w));
      if (w) chk(req, "bus_wdata", seen_wdata, d);
      else if (!rerr) chk("R4", "read data", rd, mem_val(exp_addr));
      chk("R4", "response error", 32'(er), 32'(rerr));
      chk("R10", "active cycles", 32'(act_cnt - a0), 32'(lat + 1));
      if (!bank && !rerr && m_inc == 2'd1)
        m_tar = {m_tar[31:10], 10'(m_tar[9:0] + (10'd1 << es))};
    end
    reg_chk(8'h04, m_tar, req);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R1 reset state
    chk("R1", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk("R1", "bus_req idle", 32'(bus_req), 32'd0);
    reg_chk(8'h00, 32'h0030_3602, "R1");
    reg_chk(8'h04, 32'h0, "R1");

    // R2 field layout, read-only bits, unmapped offsets
    set_csw(3'd0, 2'd1, 3'b010, 4'hA, 2'b01);
    reg_chk(8'h00, csw_exp(), "R2");
    reg_wr(8'h08, 32'hFFFF_FFFF);
    reg_chk(8'h08, 32'h0, "R2");
    reg_chk(8'h20, 32'h0, "R2");
    reg_chk(8'h00, csw_exp(), "R2");

    // R5 byte steps across the 1 KB edge, upper bits kept
    set_tar(32'h1234_03FE);
    data_acc(8'h0C, 1'b1, 32'hDEAD_0001, 1'b0, 0, "R5");
    data_acc(8'h0C, 1'b1, 32'hDEAD_0002, 1'b0, 0, "R5");
    chk("R5", "wrapped address", m_tar, 32'h1234_0000);
    data_acc(8'h0C, 1'b0, '0, 1'b0, 2, "R3");
    set_csw(3'd1, 2'd1, 3'b010, 4'hA, 2'b01);
    set_tar(32'h1234_03FE);
    data_acc(8'h0C, 1'b1, 32'h0000_BEEF, 1'b0, 1, "R5");
    set_csw(3'd5, 2'd1, 3'b011, 4'h0, 2'b11);
    set_tar(32'h0ABC_07FC);
    data_acc(8'h0C, 1'b1, 32'h1111_2222, 1'b0, 0, "R3");
    chk("R5", "word wrap", m_tar, 32'h0ABC_0400);
    data_acc(8'h0C, 1'b0, '0, 1'b0, 3, "R4");

    // R6 no step on error or with other step modes
    data_acc(8'h0C, 1'b0, '0, 1'b1, 1, "R6");
    set_csw(3'd2, 2'd0, 3'b011, 4'h0, 2'b11);
    data_acc(8'h0C, 1'b1, 32'h3333_4444, 1'b0, 0, "R6");
    set_csw(3'd2, 2'd2, 3'b011, 4'h0, 2'b11);
    data_acc(8'h0C, 1'b0, '0, 1'b0, 0, "R6");

    // R7 banked windows
    set_csw(3'd0, 2'd1, 3'b011, 4'h0, 2'b11);
    set_tar(32'h0000_0100);
    for (int k = 0; k < 4; k++)
      data_acc(8'h10 + 8'(4 * k), 1'b0, '0, 1'b0, 1, "R7");
    data_acc(8'h1C, 1'b1, 32'h5555_6666, 1'b0, 0, "R7");

    // R8 debug enable low
    dbg_en_i = 1'b0;
    reg_chk(8'h00, csw_exp(), "R8");
    data_acc(8'h0C, 1'b0, '0, 1'b0, 0, "R8");
    data_acc(8'h14, 1'b1, 32'h7, 1'b0, 0, "R8");
    dbg_en_i = 1'b1;

    // R9 secure enable low
    sec_en_i = 1'b0;
    set_csw(3'd2, 2'd1, 3'b010, 4'h0, 2'b11);
    data_acc(8'h0C, 1'b1, 32'h9999_0000, 1'b0, 0, "R9");
    set_csw(3'd2, 2'd1, 3'b000, 4'h0, 2'b11);
    reg_chk(8'h00, csw_exp(), "R9");
    data_acc(8'h0C, 1'b0, '0, 1'b0, 0, "R9");
    sec_en_i = 1'b1;
    data_acc(8'h0C, 1'b0, '0, 1'b0, 0, "R9");

    // R10 long latency stall
    data_acc(8'h0C, 1'b1, 32'hAAAA_5555, 1'b0, 4, "R10");
    reg_chk(8'h00, csw_exp(), "R10");

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule